// File: doc/BRIEF.md
# Four-Mode Serial Port with Multiprocessor Addressing

This block is a serial port that can run in one synchronous mode and three asynchronous modes, all paced by one shared baud generator. In the synchronous shift mode the port drives a shift clock and moves eight bits per transfer. The bits go out on `txd` while the bits arriving on `rxd` are captured at the same time, so one transfer both writes to and reads from an external shift register. The asynchronous modes send and receive frames with a start bit and a stop bit. The 8-bit mode can give up its top data bit to even parity. The two 9-bit modes carry an address marker in the ninth bit, which lets several receivers share one line.

The host drives the configuration, the transmit data and the control strobes directly. It reads back the received data, the received ninth bit and the sticky event flags. In the address-filtered 9-bit mode, a frame whose ninth bit is 0 still updates the receive data register, but it raises no receive flag. A node can therefore stay quiet until a frame addresses it. The baud generator is a 15-bit reload counter. It counts either main clock cycles or rising edges of an external timer clock.

Top module: `mm_serial_port`

## Requirements
- R1: After reset, `txd` and `sclk` are 1, `tx_busy` is 0, and `tx_int`, `rx_int`, `par_err` and `frame_err` are 0. While no transfer is running, `txd` and `sclk` stay at 1.
- R2: In mode 1 (`cfg_mode`=1) a frame is a 0 start bit, eight data bits least significant first, then a 1 stop bit. Each bit lasts 16 baud ticks. Such a frame on `rxd` is received into `rx_data` and sets `rx_int`.
- R3: In mode 1 with `cfg_par_en`=1, the eighth data bit sent is the even parity of `tx_data[6:0]`. On receive, a frame whose eight data bits hold an odd number of ones sets `par_err`. `par_err` stays set until a `status_rd` pulse clears it.
- R4: In modes 2 and 3 a frame is a 0 start bit, nine data bits least significant first, then a 1 stop bit. The ninth bit is `tx_bit9`, except in mode 3 with `cfg_par_en`=1, where it is the even parity of `tx_data`.
- R5: In mode 2, a received frame with ninth bit 0 updates `rx_data` and leaves `rx_int` unchanged. A received frame with ninth bit 1 sets `rx_int` and `rx_bit9`.
- R6: In mode 3, every received frame sets `rx_int` and loads its ninth bit into `rx_bit9`. With `cfg_par_en`=1, an odd count of ones over the nine bits sets `par_err`.
- R7: A low pulse on `rxd` that has returned to 1 by the middle of the start bit (tick 8 of 16) is discarded. `rx_data` and `rx_int` stay unchanged, and the next valid frame is received normally.
- R8: A received frame whose stop bit samples 0 sets `frame_err`. `frame_err` stays set until a `status_rd` pulse clears it.
- R9: In mode 0 (`cfg_mode`=0), a transfer shifts `tx_data` out on `txd` least significant bit first, with 4 baud ticks per bit. `sclk` is 0 for the first 2 ticks of each bit and 1 for the last 2. The eight bits on `rxd` are captured LSB first into `rx_data`. At the end, both `tx_int` and `rx_int` are set.
- R10: A baud tick occurs once every `cfg_reload`+1 source events. A source event is a main clock cycle when `cfg_src_ext`=0, or a rising edge of `ext_clk` when `cfg_src_ext`=1.
- R11: A `tx_start` pulse while `tx_busy` is 1 is ignored. The frame in flight is unchanged, and no second frame follows it.
- R12: `tx_int` is set at the end of each transfer and stays set until a `tx_int_clr` pulse. `rx_int` stays set until a `rx_int_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 shift, 1 async 8-bit, 2 async 9-bit address-filtered, 3 async 9-bit |
| cfg_par_en | input | 1 | Even parity enable (modes 1 and 3) |
| cfg_src_ext | input | 1 | Baud source: 0 main clock, 1 `ext_clk` rising edges |
| cfg_reload | input | 15 | Baud counter reload value |
| ext_clk | input | 1 | External timer clock input |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in modes 2 and 3 |
| tx_start | input | 1 | One-cycle pulse that starts a transfer |
| tx_busy | output | 1 | Transfer in progress |
| rx_data | output | 8 | Last received byte |
| rx_bit9 | output | 1 | Ninth bit of the last 9-bit frame |
| rx_int | output | 1 | Sticky receive flag |
| tx_int | output | 1 | Sticky transmit-done flag |
| par_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |
| rx_int_clr | input | 1 | Clears `rx_int` |
| tx_int_clr | input | 1 | Clears `tx_int` |
| status_rd | input | 1 | Status read pulse; clears `par_err` and `frame_err` |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| sclk | output | 1 | Shift clock (mode 0) |

## Verification
The assertions check four things on every cycle:
- the idle level of both lines;
- that `sclk` only goes low inside a mode 0 transfer;
- that an asynchronous frame always opens with a low start bit;
- the minimum spacing of baud ticks.

They also check that each sticky flag drops only in the cycle after its own clear strobe. The bench scenarios cover the rest, which depends on whole frames:
- bit order and parity substitution;
- address filtering in mode 2;
- false-start rejection and framing errors;
- the full-duplex capture of mode 0;
- ignoring a start request while busy.

The bench checks these against a queue-based frame model sampled at each bit centre.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int BAUD_W   = 15;
    localparam int OVS      = 16;
    localparam int SYNC_BIT = 4;
    localparam int FRAME_W  = 11;

    typedef enum logic [1:0] {
        SP_SHIFT    = 2'd0,
        SP_ASYNC8   = 2'd1,
        SP_ASYNC9A  = 2'd2,
        SP_ASYNC9   = 2'd3
    } sp_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } sp_rx_st_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
        logic       perr;
        logic       ferr;
        logic       accept;
    } sp_rx_res_t;

    function automatic logic even_bit(input logic [8:0] v);
        return ^v;
    endfunction
endpackage

// File: rtl/sp_baud.sv
module sp_baud
    import sp_pkg::*;
#(
    parameter int W = BAUD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         src_ext,
    input  logic         ext_clk,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [2:0]   ext_q;
    logic [W-1:0] cnt;
    logic         event_p;

    assign event_p = src_ext ? (ext_q[1] & ~ext_q[2]) : 1'b1;
    assign tick    = event_p && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= '0;
            cnt   <= '0;
        end else begin
            ext_q <= {ext_q[1:0], ext_clk};
            if (event_p) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int OV = OVS,
    parameter int SB = SYNC_BIT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  sp_mode_e   mode,
    input  logic       par_en,
    input  logic [7:0] data,
    input  logic       bit9,
    input  logic       start,
    input  logic       rxd_s,
    output logic       txd,
    output logic       sclk,
    output logic       busy,
    output logic       done,
    output logic       cap_valid,
    output logic [7:0] cap_data
);
    localparam int SW   = $clog2(OV);
    localparam int HALF = SB / 2;

    logic [FRAME_W-1:0] shreg, frame;
    logic [3:0]         idx, last_idx, frame_last;
    logic [SW-1:0]      sub, sub_last;
    logic               is_sync;
    logic               b8, b9;

    always_comb begin
        b8 = par_en ? even_bit({2'b00, data[6:0]}) : data[7];
        b9 = (par_en && mode == SP_ASYNC9) ? even_bit({1'b0, data}) : bit9;
        unique case (mode)
            SP_SHIFT: begin
                frame      = {3'b111, data};
                frame_last = 4'd7;
            end
            SP_ASYNC8: begin
                frame      = {2'b11, b8, data[6:0], 1'b0};
                frame_last = 4'd9;
            end
            default: begin
                frame      = {1'b1, b9, data, 1'b0};
                frame_last = 4'd10;
            end
        endcase
    end

    assign sub_last = is_sync ? SW'(SB - 1) : SW'(OV - 1);
    assign txd      = busy ? shreg[0] : 1'b1;
    assign sclk     = !(busy && is_sync && (sub < SW'(HALF)));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            shreg     <= '1;
            sub       <= '0;
            idx       <= '0;
            last_idx  <= '0;
            is_sync   <= 1'b0;
            done      <= 1'b0;
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            done      <= 1'b0;
            cap_valid <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    shreg    <= frame;
                    idx      <= '0;
                    last_idx <= frame_last;
                    sub      <= '0;
                    is_sync  <= (mode == SP_SHIFT);
                end
            end else if (tick) begin
                if (is_sync && sub == SW'(SB - 1))
                    cap_data <= {rxd_s, cap_data[7:1]};
                if (sub == sub_last) begin
                    sub   <= '0;
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    if (idx == last_idx) begin
                        busy      <= 1'b0;
                        done      <= 1'b1;
                        cap_valid <= is_sync;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int OV = OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  sp_mode_e   mode,
    input  logic       par_en,
    input  logic       rxd_s,
    output logic       res_valid,
    output sp_rx_res_t res
);
    localparam int SW  = $clog2(OV);
    localparam int MID = OV / 2 - 1;

    sp_rx_st_e     st;
    sp_mode_e      r_mode;
    logic          r_par;
    logic          rxd_d;
    logic [SW-1:0] sub;
    logic [3:0]    idx;
    logic [8:0]    rbits;
    logic          perr;

    always_comb begin
        if (r_par && r_mode == SP_ASYNC8)     perr = even_bit({1'b0, rbits[7:0]});
        else if (r_par && r_mode == SP_ASYNC9) perr = even_bit(rbits);
        else                                   perr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            r_mode    <= SP_ASYNC8;
            r_par     <= 1'b0;
            rxd_d     <= 1'b1;
            sub       <= '0;
            idx       <= '0;
            rbits     <= '0;
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            rxd_d     <= rxd_s;
            res_valid <= 1'b0;
            if (st == RX_IDLE) begin
                if (mode != SP_SHIFT && rxd_d && !rxd_s) begin
                    st     <= RX_START;
                    sub    <= '0;
                    rbits  <= '0;
                    r_mode <= mode;
                    r_par  <= par_en;
                end
            end else if (tick) begin
                if (sub == SW'(MID)) begin
                    if (st == RX_START && rxd_s) begin
                        st <= RX_IDLE;
                    end else if (st == RX_DATA) begin
                        rbits[idx] <= rxd_s;
                    end else if (st == RX_STOP) begin
                        st         <= RX_IDLE;
                        res_valid  <= 1'b1;
                        res.data   <= rbits[7:0];
                        res.bit9   <= rbits[8];
                        res.perr   <= perr;
                        res.ferr   <= !rxd_s;
                        res.accept <= !(r_mode == SP_ASYNC9A && !rbits[8]);
                    end
                end
                if (sub == SW'(OV - 1)) begin
                    sub <= '0;
                    if (st == RX_START) begin
                        st  <= RX_DATA;
                        idx <= '0;
                    end else if (st == RX_DATA) begin
                        if (idx == ((r_mode == SP_ASYNC8) ? 4'd7 : 4'd8)) st <= RX_STOP;
                        else idx <= idx + 1'b1;
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mm_serial_port.sv
module mm_serial_port
    import sp_pkg::*;
#(
    parameter int RELOAD_W = BAUD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_par_en,
    input  logic                cfg_src_ext,
    input  logic [RELOAD_W-1:0] cfg_reload,
    input  logic                ext_clk,
    input  logic [7:0]          tx_data,
    input  logic                tx_bit9,
    input  logic                tx_start,
    output logic                tx_busy,
    output logic [7:0]          rx_data,
    output logic                rx_bit9,
    output logic                rx_int,
    output logic                tx_int,
    output logic                par_err,
    output logic                frame_err,
    input  logic                rx_int_clr,
    input  logic                tx_int_clr,
    input  logic                status_rd,
    output logic                txd,
    input  logic                rxd,
    output logic                sclk
);
    logic       baud_tick;
    logic [1:0] rxd_q;
    logic       tx_done, cap_valid, res_valid;
    logic [7:0] cap_data;
    sp_rx_res_t res;
    sp_mode_e   mode;

    assign mode = sp_mode_e'(cfg_mode);

    always_ff @(posedge clk) begin
        if (rst) rxd_q <= 2'b11;
        else     rxd_q <= {rxd_q[0], rxd};
    end

    sp_baud #(.W(RELOAD_W)) u_baud (
        .clk(clk), .rst(rst), .src_ext(cfg_src_ext), .ext_clk(ext_clk),
        .reload(cfg_reload), .tick(baud_tick)
    );

    sp_tx u_tx (
        .clk(clk), .rst(rst), .tick(baud_tick), .mode(mode), .par_en(cfg_par_en),
        .data(tx_data), .bit9(tx_bit9), .start(tx_start), .rxd_s(rxd_q[1]),
        .txd(txd), .sclk(sclk), .busy(tx_busy), .done(tx_done),
        .cap_valid(cap_valid), .cap_data(cap_data)
    );

    sp_rx u_rx (
        .clk(clk), .rst(rst), .tick(baud_tick), .mode(mode), .par_en(cfg_par_en),
        .rxd_s(rxd_q[1]), .res_valid(res_valid), .res(res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_int    <= 1'b0;
            tx_int    <= 1'b0;
            par_err   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (tx_done)         tx_int <= 1'b1;
            else if (tx_int_clr) tx_int <= 1'b0;

            if (cap_valid || (res_valid && res.accept)) rx_int <= 1'b1;
            else if (rx_int_clr)                        rx_int <= 1'b0;

            if (cap_valid) begin
                rx_data <= cap_data;
            end else if (res_valid) begin
                rx_data <= res.data;
                rx_bit9 <= res.bit9;
            end

            if (res_valid && res.perr) par_err <= 1'b1;
            else if (status_rd)        par_err <= 1'b0;

            if (res_valid && res.ferr) frame_err <= 1'b1;
            else if (status_rd)        frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/sp_chk.sv
module sp_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cfg_mode,
    input logic [14:0] cfg_reload,
    input logic        baud_tick,
    input logic        tx_busy,
    input logic        txd,
    input logic        sclk,
    input logic        tx_int,
    input logic        tx_int_clr,
    input logic        rx_int,
    input logic        rx_int_clr,
    input logic        par_err,
    input logic        frame_err,
    input logic        status_rd
);
    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> (txd && sclk));

    // R9
    sclk_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> (tx_busy && cfg_mode == 2'd0));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_busy) && cfg_mode != 2'd0) |-> !txd);

    // R10
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && cfg_reload != '0) |=> !baud_tick);

    // R12
    tx_int_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_int) |-> $past(tx_int_clr));

    // R12
    rx_int_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_int) |-> $past(rx_int_clr));

    // R3
    par_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(par_err) |-> $past(status_rd));

    // R8
    ferr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_err) |-> $past(status_rd));
endmodule

bind mm_serial_port sp_chk u_chk (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_reload(cfg_reload),
    .baud_tick(baud_tick), .tx_busy(tx_busy), .txd(txd), .sclk(sclk),
    .tx_int(tx_int), .tx_int_clr(tx_int_clr), .rx_int(rx_int),
    .rx_int_clr(rx_int_clr), .par_err(par_err), .frame_err(frame_err),
    .status_rd(status_rd)
);

// File: tb/mm_serial_port_tb.sv
module mm_serial_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd1;
    logic        cfg_par_en = 1'b0;
    logic        cfg_src_ext = 1'b0;
    logic [14:0] cfg_reload = '0;
    logic        ext_clk = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_bit9 = 1'b0;
    logic        tx_start = 1'b0;
    logic        tx_busy;
    logic [7:0]  rx_data;
    logic        rx_bit9, rx_int, tx_int, par_err, frame_err;
    logic        rx_int_clr = 1'b0, tx_int_clr = 1'b0, status_rd = 1'b0;
    logic        txd, sclk;
    logic        rxd = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    initial forever begin
        repeat (2) @(posedge clk);
        ext_clk = ~ext_clk;
    end

    mm_serial_port u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_par_en(cfg_par_en),
        .cfg_src_ext(cfg_src_ext), .cfg_reload(cfg_reload), .ext_clk(ext_clk),
        .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_start(tx_start), .tx_busy(tx_busy),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_int(rx_int), .tx_int(tx_int),
        .par_err(par_err), .frame_err(frame_err), .rx_int_clr(rx_int_clr),
        .tx_int_clr(tx_int_clr), .status_rd(status_rd), .txd(txd), .rxd(rxd), .sclk(sclk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: tx_int_clr = 1'b1;
            1: rx_int_clr = 1'b1;
            default: status_rd = 1'b1;
        endcase
        @(negedge clk);
        tx_int_clr = 1'b0; rx_int_clr = 1'b0; status_rd = 1'b0;
    endtask

    // Reference frame model: expected line bits in send order.
    task automatic model_frame(input logic [1:0] m, input logic pe, input logic [7:0] d,
                               input logic b9, ref logic q[$]);
        q = {};
        if (m != 2'd0) q.push_back(1'b0);
        for (int i = 0; i < 7; i++) q.push_back(d[i]);
        if (m == 2'd1) q.push_back(pe ? ((^d[6:0]) & 1'b1) : d[7]);
        else           q.push_back(d[7]);
        if (m >= 2'd2) q.push_back((m == 2'd3 && pe) ? ^d : b9);
        if (m != 2'd0) q.push_back(1'b1);
    endtask

    task automatic send_tx(input string req, input logic [1:0] m, input logic pe,
                           input logic [7:0] d, input logic b9, input int P,
                           input bit poke, input logic [7:0] slave);
        logic q[$];
        model_frame(m, pe, d, b9, q);
        cfg_mode = m; cfg_par_en = pe; tx_data = d; tx_bit9 = b9;
        if (m == 2'd0) begin
            fork
                for (int i = 0; i < 8; i++) begin
                    @(negedge sclk);
                    rxd = slave[i];
                end
            join_none
        end
        @(negedge clk) tx_start = 1'b1;
        @(posedge clk);
        @(negedge clk) tx_start = 1'b0;
        if (m == 2'd0) chk("R9", sclk, 1'b0, "sclk low in first half of bit");
        repeat (P / 2) @(negedge clk);
        if (m == 2'd0) chk("R9", sclk, 1'b1, "sclk high in second half of bit");
        for (int k = 0; k < q.size(); k++) begin
            chk(req, txd, q[k], $sformatf("txd bit %0d", k));
            if (poke && k == 3) begin
                tx_data = ~d; tx_start = 1'b1;
                @(negedge clk) tx_start = 1'b0;
                tx_data = d;
                repeat (P - 1) @(negedge clk);
            end else begin
                repeat (P) @(negedge clk);
            end
        end
        rxd = 1'b1;
        chk("R12", tx_int, 1'b1, "tx_int set at end");
        chk(poke ? "R11" : req, tx_busy, 1'b0, "busy clear after frame");
        if (m == 2'd0) begin
            chk("R9", rx_data, slave, "mode 0 captured byte");
            chk("R9", rx_int, 1'b1, "mode 0 rx_int");
            strobe(1);
        end
        repeat (3) @(negedge clk);
        chk("R12", tx_int, 1'b1, "tx_int held");
        strobe(0);
        chk("R12", tx_int, 1'b0, "tx_int cleared");
    endtask

    task automatic send_rx(input logic [1:0] m, input logic pe, input logic [8:0] bits,
                           input logic stop, input int P);
        int nb;
        nb = (m == 2'd1) ? 8 : 9;
        cfg_mode = m; cfg_par_en = pe;
        @(negedge clk) rxd = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = bits[i];
            repeat (P) @(negedge clk);
        end
        rxd = stop;
        repeat (P) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", txd, 1'b1, "txd idle");
        chk("R1", sclk, 1'b1, "sclk idle");
        chk("R1", tx_busy, 1'b0, "busy idle");
        chk("R1", {tx_int, rx_int, par_err, frame_err}, 4'b0, "flags idle");

        send_tx("R2", 2'd1, 1'b0, 8'hA5, 1'b0, 16, 0, 8'h00);
        send_tx("R3", 2'd1, 1'b1, 8'h37, 1'b0, 16, 0, 8'h00);
        send_tx("R4", 2'd2, 1'b0, 8'h5A, 1'b1, 16, 0, 8'h00);
        send_tx("R4", 2'd3, 1'b1, 8'h01, 1'b0, 16, 0, 8'h00);
        send_tx("R11", 2'd1, 1'b0, 8'h96, 1'b0, 16, 1, 8'h00);
        cfg_reload = 15'd2;
        send_tx("R10", 2'd1, 1'b0, 8'h3C, 1'b0, 48, 0, 8'h00);
        cfg_reload = 15'd0; cfg_src_ext = 1'b1;
        send_tx("R10", 2'd1, 1'b0, 8'hC9, 1'b0, 64, 0, 8'h00);
        cfg_src_ext = 1'b0;
        send_tx("R9", 2'd0, 1'b0, 8'hC3, 1'b0, 4, 0, 8'h6B);

        // R2 receive in mode 1
        send_rx(2'd1, 1'b0, 9'h03C, 1'b1, 16);
        chk("R2", rx_data, 8'h3C, "rx data mode 1");
        chk("R2", rx_int, 1'b1, "rx_int mode 1");
        repeat (3) @(negedge clk);
        chk("R12", rx_int, 1'b1, "rx_int held");
        strobe(1);
        chk("R12", rx_int, 1'b0, "rx_int cleared");

        // R3 bad parity in mode 1
        send_rx(2'd1, 1'b1, 9'h083, 1'b1, 16);
        chk("R3", rx_data, 8'h83, "rx data with parity bit");
        chk("R3", par_err, 1'b1, "parity error set");
        strobe(2);
        chk("R3", par_err, 1'b0, "parity error cleared by status read");
        strobe(1);

        // R5 address filter in mode 2
        send_rx(2'd2, 1'b0, 9'h011, 1'b1, 16);
        chk("R5", rx_data, 8'h11, "data frame updates rx_data");
        chk("R5", rx_int, 1'b0, "data frame raises no rx_int");
        send_rx(2'd2, 1'b0, 9'h122, 1'b1, 16);
        chk("R5", rx_int, 1'b1, "address frame raises rx_int");
        chk("R5", rx_bit9, 1'b1, "address frame ninth bit");
        strobe(1);

        // R6 mode 3 every frame, parity over nine bits
        send_rx(2'd3, 1'b1, 9'h044, 1'b1, 16);
        chk("R6", rx_int, 1'b1, "mode 3 rx_int");
        chk("R6", rx_bit9, 1'b0, "mode 3 ninth bit");
        chk("R6", par_err, 1'b0, "mode 3 good parity");
        strobe(1);
        send_rx(2'd3, 1'b1, 9'h144, 1'b1, 16);
        chk("R6", par_err, 1'b1, "mode 3 bad parity");
        chk("R6", rx_int, 1'b1, "mode 3 rx_int on bad parity");
        strobe(2); strobe(1);

        // R7 false start
        cfg_mode = 2'd1; cfg_par_en = 1'b0;
        @(negedge clk) rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk("R7", rx_int, 1'b0, "false start no rx_int");
        chk("R7", rx_data, 8'h44, "false start keeps rx_data");
        send_rx(2'd1, 1'b0, 9'h0E7, 1'b1, 16);
        chk("R7", rx_data, 8'hE7, "frame after false start");
        strobe(1);

        // R8 framing error
        send_rx(2'd1, 1'b0, 9'h099, 1'b0, 16);
        chk("R8", frame_err, 1'b1, "framing error set");
        repeat (3) @(negedge clk);
        chk("R8", frame_err, 1'b1, "framing error held");
        strobe(2);
        chk("R8", frame_err, 1'b0, "framing error cleared");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule